// File: doc/BRIEF.md
# Flow-Through Synchronous SRAM

This block is a synthesizable behavioural model of a single-ported synchronous SRAM. Reads use a flow-through path: the address is registered on a clock edge and the stored word reaches the output during the cycle that follows, with no second register in the path. Writes are late by one cycle. The address and the write command are registered on one edge, and the data and byte selects are taken on the next enabled edge. A new command may be issued on that same edge, so a stream of mixed reads and writes runs with no idle cycle between them.

A held clock enable freezes the whole block. Three chip-select inputs must all be active for a command to load. A load strobe chooses between loading a new address and continuing the current access. When the access continues, the two low address bits step linearly and wrap within a group of four words, and the read or write type stays the same. The output bus is split from the input bus. An output-valid flag stands in for a tri-state driver and is gated at once by an active-low output enable.

Top module: `sram_ft`

## Requirements
- R1: Synchronous active-high reset clears every word of the array to zero, ends any access in progress, and holds `dout_vld` low.
- R2: While `cken_n` is high, a clock edge changes nothing. The output keeps its state, and a pending write waits for the next edge with `cken_n` low before it takes its data.
- R3: A command loads only at an edge where `cken_n`=0, `ce0_n`=0, `ce1`=1, `ce2_n`=0 and `load_n`=0. With `wr_n`=1 it is a read, and with `wr_n`=0 it is a write.
- R4: In the cycle after a read command edge, `dout` carries the stored word at the registered address.
- R5: `dout_vld` is high only during a read data cycle while `oe_n` is low. `oe_n` acts on it combinationally, within the same cycle.
- R6: A write stores data on the next enabled edge after its command. Byte i occupies bits 8i+7:8i and is written only if `bsel_n[i]`=0. Bytes whose select is high keep their old value.
- R7: During a write data cycle, `dout_vld` stays low whatever the level of `oe_n`.
- R8: The edge that captures write data may also load a new command. A read of the same address issued on that edge returns the merged new word.
- R9: If `load_n`=0 and any chip select is inactive at an enabled edge, the access ends and `dout_vld` is low in the next cycle.
- R10: If `load_n`=1 at an enabled edge while an access is active, the address bits 1:0 increment modulo 4 and the upper bits stay the same. The access keeps its read or write type, and the chip selects are ignored. After a deselect or reset, `load_n`=1 starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cken_n | input | 1 | Clock enable, active low |
| ce0_n | input | 1 | Chip select, active low |
| ce1 | input | 1 | Chip select, active high |
| ce2_n | input | 1 | Chip select, active low |
| load_n | input | 1 | Low loads a new command; high continues the access |
| wr_n | input | 1 | Low selects write, high selects read |
| bsel_n | input | NB (4) | Byte write selects, active low |
| addr | input | AW (6) | Word address |
| oe_n | input | 1 | Output enable, active low, combinational |
| din | input | NB*BW (32) | Write data |
| dout | output | NB*BW (32) | Read data, zero outside read cycles |
| dout_vld | output | 1 | Output driven (tri-state stand-in) |

## Verification
If the registered address were wrong, the block would return the wrong word on the very next read cycle. A fault in the burst step would show up on the second word of a continued access. If the pending-write flag were lost or did not hold, the fault would surface as a stale word on the read issued at the capture edge, which is the earliest point. If the phase flags were wrong, `dout_vld` would be raised during a write data cycle or after a deselect, and that can be seen in the same cycle. The bench keeps a model of the array and the phase, and compares `dout_vld` and `dout` against it on every cycle.

// File: rtl/sram_ft_pkg.sv
package sram_ft_pkg;

    localparam int STEP_BITS = 2;

    typedef enum logic [1:0] {
        CMD_IDLE,
        CMD_LOAD,
        CMD_DESEL,
        CMD_NEXT
    } cmd_e;

    typedef struct packed {
        logic rd;
        logic wr;
    } phase_t;

    function automatic cmd_e decode_cmd(input logic ce_all, input logic load_n,
                                        input logic active);
        if (!load_n) return ce_all ? CMD_LOAD : CMD_DESEL;
        return active ? CMD_NEXT : CMD_IDLE;
    endfunction

    function automatic logic [STEP_BITS-1:0] step_wrap(input logic [STEP_BITS-1:0] b);
        return b + 1'b1;
    endfunction

endpackage

// File: rtl/sram_ft_ctrl.sv
module sram_ft_ctrl
    import sram_ft_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cken_n,
    input  logic          ce_all,
    input  logic          load_n,
    input  logic          wr_n,
    input  logic [AW-1:0] addr,
    output logic [AW-1:0] addr_q,
    output logic          rd_phase,
    output logic          wr_phase
);

    logic   active;
    logic   is_wr;
    phase_t ph;
    cmd_e   cmd;

    assign cmd      = decode_cmd(ce_all, load_n, active);
    assign rd_phase = ph.rd;
    assign wr_phase = ph.wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            is_wr  <= 1'b0;
            addr_q <= '0;
            ph     <= '0;
        end else if (!cken_n) begin
            unique case (cmd)
                CMD_LOAD: begin
                    active <= 1'b1;
                    is_wr  <= !wr_n;
                    addr_q <= addr;
                    ph.rd  <= wr_n;
                    ph.wr  <= !wr_n;
                end
                CMD_DESEL: begin
                    active <= 1'b0;
                    ph     <= '0;
                end
                CMD_NEXT: begin
                    addr_q <= {addr_q[AW-1:STEP_BITS], step_wrap(addr_q[STEP_BITS-1:0])};
                    ph.rd  <= !is_wr;
                    ph.wr  <= is_wr;
                end
                default: ph <= '0;
            endcase
        end
    end

    // R2: held clock enable freezes address and phase
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        cken_n |=> ($stable(addr_q) && $stable(ph)));

    // R3: a read command opens a read cycle, not a write cycle
    a_r3_read_start: assert property (@(posedge clk) disable iff (rst)
        (!cken_n && !load_n && ce_all && wr_n) |=> (rd_phase && !wr_phase));

    // R9: deselect closes any access
    a_r9_deselect: assert property (@(posedge clk) disable iff (rst)
        (!cken_n && !load_n && !ce_all) |=> (!rd_phase && !wr_phase));

    // R10: continuation wraps the low two address bits
    a_r10_wrap: assert property (@(posedge clk) disable iff (rst)
        (!cken_n && load_n && active) |=>
            (addr_q[1:0] == $past(addr_q[1:0]) + 2'd1 &&
             addr_q[AW-1:2] == $past(addr_q[AW-1:2])));

endmodule

// File: rtl/sram_ft_array.sv
module sram_ft_array #(
    parameter int AW = 6,
    parameter int NB = 4,
    parameter int BW = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [NB-1:0]    bsel_n,
    input  logic [NB*BW-1:0] wdata,
    output logic [NB*BW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;
    localparam int DW    = NB * BW;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] merged;

    generate
        for (genvar b = 0; b < NB; b++) begin : g_lane
            assign merged[b*BW +: BW] = bsel_n[b] ? mem[addr][b*BW +: BW]
                                                  : wdata[b*BW +: BW];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[addr] <= merged;
        end
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/sram_ft.sv
module sram_ft #(
    parameter int AW = 6,
    parameter int NB = 4,
    parameter int BW = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cken_n,
    input  logic             ce0_n,
    input  logic             ce1,
    input  logic             ce2_n,
    input  logic             load_n,
    input  logic             wr_n,
    input  logic [NB-1:0]    bsel_n,
    input  logic [AW-1:0]    addr,
    input  logic             oe_n,
    input  logic [NB*BW-1:0] din,
    output logic [NB*BW-1:0] dout,
    output logic             dout_vld
);

    localparam int DW = NB * BW;

    logic          ce_all;
    logic [AW-1:0] addr_q;
    logic          rd_phase;
    logic          wr_phase;
    logic [DW-1:0] rdata;

    assign ce_all = !ce0_n && ce1 && !ce2_n;

    sram_ft_ctrl #(.AW(AW)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .cken_n   (cken_n),
        .ce_all   (ce_all),
        .load_n   (load_n),
        .wr_n     (wr_n),
        .addr     (addr),
        .addr_q   (addr_q),
        .rd_phase (rd_phase),
        .wr_phase (wr_phase)
    );

    sram_ft_array #(.AW(AW), .NB(NB), .BW(BW)) u_array (
        .clk    (clk),
        .rst    (rst),
        .we     (wr_phase && !cken_n),
        .addr   (addr_q),
        .bsel_n (bsel_n),
        .wdata  (din),
        .rdata  (rdata)
    );

    assign dout     = rd_phase ? rdata : '0;
    assign dout_vld = rd_phase && !oe_n;

    // R7: no drive while write data is on the bus
    a_r7_wdata_quiet: assert property (@(posedge clk) disable iff (rst)
        wr_phase |-> !dout_vld);

endmodule

// File: tb/sram_ft_test.sv
module sram_ft_test;

    localparam int AW = 6;
    localparam int NB = 4;
    localparam int BW = 8;
    localparam int DW = NB * BW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cken_n = 1'b0, ce0_n = 1'b0, ce1 = 1'b1, ce2_n = 1'b0;
    logic load_n = 1'b1, wr_n = 1'b1, oe_n = 1'b0;
    logic [NB-1:0] bsel_n = '0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic dout_vld;

    int errors = 0;
    int checks = 0;

    // behavioural reference state
    logic [DW-1:0] mm [64];
    bit m_active, m_wr, m_rd, m_wp;
    int m_addr;

    always #10 clk = ~clk;

    sram_ft #(.AW(AW), .NB(NB), .BW(BW)) uut (
        .clk(clk), .rst(rst), .cken_n(cken_n), .ce0_n(ce0_n), .ce1(ce1),
        .ce2_n(ce2_n), .load_n(load_n), .wr_n(wr_n), .bsel_n(bsel_n),
        .addr(addr), .oe_n(oe_n), .din(din), .dout(dout), .dout_vld(dout_vld)
    );

    task automatic compare(input string tag);
        bit ev;
        ev = m_rd && !oe_n && !rst;
        checks++;
        if (dout_vld !== ev) begin
            errors++;
            $display("FAIL %s dout_vld got %b exp %b", tag, dout_vld, ev);
        end
        if (ev) begin
            checks++;
            if (dout !== mm[m_addr]) begin
                errors++;
                $display("FAIL %s dout got %h exp %h", tag, dout, mm[m_addr]);
            end
        end
    endtask

    task automatic model_edge();
        bit nwp, nrd, ce;
        if (rst) begin
            for (int i = 0; i < 64; i++) mm[i] = '0;
            m_active = 0; m_wr = 0; m_rd = 0; m_wp = 0; m_addr = 0;
            return;
        end
        if (cken_n) return;
        if (m_wp)
            for (int b = 0; b < NB; b++)
                if (!bsel_n[b]) mm[m_addr][b*BW +: BW] = din[b*BW +: BW];
        nwp = 0; nrd = 0;
        ce = !ce0_n && ce1 && !ce2_n;
        if (!load_n && ce) begin
            m_active = 1; m_wr = !wr_n; m_addr = addr;
            if (m_wr) nwp = 1; else nrd = 1;
        end else if (!load_n) begin
            m_active = 0;
        end else if (m_active) begin
            m_addr = (m_addr & ~3) | ((m_addr + 1) & 3);
            if (m_wr) nwp = 1; else nrd = 1;
        end
        m_wp = nwp; m_rd = nrd;
    endtask

    // inputs are set just after a falling edge; check, then pass the rising edge
    task automatic tick(input string tag);
        #5 compare(tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic cmd(input bit w, input int a, input logic [NB-1:0] bs,
                       input logic [DW-1:0] d);
        load_n = 0; wr_n = !w; addr = a[AW-1:0]; bsel_n = bs; din = d;
        ce0_n = 0; ce1 = 1; ce2_n = 0; cken_n = 0;
    endtask

    initial begin
        #4000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        bit [31:0] r;
        for (int i = 0; i < 64; i++) mm[i] = '0;
        @(negedge clk);
        tick("R1");            // in reset, oe_n low: no drive
        tick("R1");
        rst = 0;
        // R1/R4: read of a cleared word
        cmd(0, 5, '1, '0); tick("R3");
        load_n = 1; ce1 = 0;   tick("R1");    // continuation read of 6
        // R6/R8: write 5, then read 5 on the capture edge
        cmd(1, 5, '1, '0); tick("R4");
        cmd(0, 5, 4'b0000, 32'hA1B2C3D4); tick("R7");
        // R7: oe_n low during write data cycle was checked above; read result now
        cmd(1, 5, '1, '0); tick("R8");
        // R6: byte write bytes 0 and 2, read on capture edge
        cmd(0, 5, 4'b1010, 32'h11223344); tick("R7");
        load_n = 0; ce1 = 0;   tick("R6");    // merged word visible; then deselect
        // R9: output off after deselect; R10: load_n high starts nothing
        load_n = 1; ce1 = 1;   tick("R9");
        tick("R10");
        // R5: oe_n gates combinationally
        cmd(0, 5, '1, '0); tick("R3");
        oe_n = 1; load_n = 1; wr_n = 1; cken_n = 1; #2 compare("R5");
        oe_n = 0; #2 compare("R5");
        oe_n = 1; tick("R5");
        oe_n = 0;
        // R2: hold during read (load_n low, other address), then during pending write
        load_n = 0; addr = 9; tick("R2");
        tick("R2");
        cmd(1, 9, '1, '0); tick("R2");
        cken_n = 1; load_n = 0; ce1 = 0; din = 32'hDEADBEEF; bsel_n = '0; tick("R2");
        tick("R2");
        cmd(0, 9, 4'b0000, 32'h0BADF00D); tick("R2");
        cken_n = 0; load_n = 1; tick("R2");
        // R10: write burst from 6 with chip selects inactive during continuation
        cmd(1, 6, '1, '0); tick("R10");
        load_n = 1; ce0_n = 1;
        din = 32'h60606060; bsel_n = 0; tick("R10");
        din = 32'h70707070; tick("R10");
        din = 32'h40404040; tick("R10");
        din = 32'h50505050; load_n = 0; ce0_n = 0; wr_n = 1; addr = 7; tick("R10");
        load_n = 1; ce1 = 0; tick("R10");
        tick("R10");
        tick("R10");
        tick("R10");
        // mixed traffic against the model
        r = 32'h1ACE_B00C;
        for (int k = 0; k < 400; k++) begin
            r = {r[30:0], r[31] ^ r[21] ^ r[1] ^ r[0]};
            cken_n = r[0] & r[1];
            ce0_n = r[2] & r[3];
            ce1 = !(r[4] & r[5]);
            ce2_n = r[6] & r[7] & r[8];
            load_n = r[9] & r[10];
            wr_n = r[11];
            bsel_n = r[15:12];
            addr = {3'b000, r[18:16]};
            oe_n = r[19] & r[20];
            din = r * 32'h9E37_79B1;
            tick("R3");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule